// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous request port and an external asynchronous static RAM. The RAM is controlled through three active-low pins: a select, a read enable and a write strobe. A requester offers one transfer at a time. Each transfer has a direction flag, an address and, for stores, a data word. The sequencer then walks the memory pins through a fixed sequence of clock cycles. The pins are driven from flops, so they change only on clock edges and carry no glitches. Read data is captured in the sequencer, and the end of the transfer is marked by a one-cycle completion pulse.

The length of each sequence is set by parameters given in nanoseconds: the core clock period, the read access time and the write cycle time. Each time is rounded up to whole clock cycles. A store is never shorter than three cycles and a load is never shorter than two. If the load would come out longer than the store, the store is stretched to match it. With the default values (20 ns clock, 65 ns read access, 80 ns write cycle), both sequences occupy four cycles, plus one hold cycle on stores.

Top module: `sram_async_ctrl`

## Requirements
- R1: After synchronous reset, select, read enable and write strobe are high, the data drive enable is low, `req_ready` is high and `rsp_done` is low.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the completion cycle. A request offered while busy has no effect on `mem_addr` or on the operation in progress.
- R3: In a store, counting the cycle after acceptance as cycle 1: select falls and the address appears in cycle 1; the data drive enable rises with the data in cycle 2; the write strobe is low from cycle 3 through cycle W, where W is the store length.
- R4: In the cycle after the write strobe rises (cycle W+1), select stays low and the address, data and drive enable are unchanged.
- R5: In a load, select falls and the address appears in cycle 1. The read enable is low from cycle 2 through cycle R, where R is the load length, and the write strobe stays high.
- R6: The value on `mem_dq_i` at the clock edge that ends cycle R is presented on `rsp_rdata` in the completion cycle of a load.
- R7: The read enable and the write strobe are never low in the same cycle, and select is low whenever either of them is low.
- R8: `rsp_done` is high for exactly one cycle: cycle W+2 of a store, or cycle R+1 of a load. In that cycle all memory control pins are idle.
- R9: R = max(ceil(read_ns/clk_ns), 2) and W = max(ceil(write_ns/clk_ns), 3, R). With the defaults, R = 4 and W = 4.
- R10: A request offered in the completion cycle is accepted at the next edge, so select is low again in the following cycle.
- R11: The data drive enable is low throughout loads and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Sequencer idle, a request can be accepted |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured load data |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq_o | output | DATA_W | Data driven to memory |
| mem_dq_oe | output | 1 | Data drive enable, 1 = drive |
| mem_dq_i | input | DATA_W | Data returned by memory |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory read enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |

## Verification
Two cases are hardest to reach from the ports. The first is a request that arrives while a store is already under way. The bench raises `req_valid` with a different address and direction in the middle of a store and holds it until the hold cycle, then checks that the address pins never move. The second is a capture that comes one cycle too early. The memory model returns a garbage word until the access delay has elapsed, so an early sample gives a visibly wrong value. Every address is stored and loaded in two passes with different arithmetic patterns. The second pass alternates stores and loads back to back in the completion cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_DATA   = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned read_len(input int unsigned rd_ns, input int unsigned clk_ns);
        return max_u(ns_to_cycles(rd_ns, clk_ns), 2);
    endfunction

    function automatic int unsigned write_len(input int unsigned wr_ns, input int unsigned rd_ns,
                                              input int unsigned clk_ns);
        return max_u(max_u(ns_to_cycles(wr_ns, clk_ns), 3), read_len(rd_ns, clk_ns));
    endfunction

    // Pin levels to hold during a phase of a load or store
    function automatic pin_ctl_t pins_for(input phase_e ph, input logic wr);
        pin_ctl_t p;
        p = PINS_IDLE;
        case (ph)
            PH_SETUP:  p.cs_n = 1'b0;
            PH_DATA: begin
                p.cs_n  = 1'b0;
                p.dq_oe = wr;
            end
            PH_STROBE: begin
                p.cs_n  = 1'b0;
                p.oe_n  = wr;
                p.we_n  = ~wr;
                p.dq_oe = wr;
            end
            PH_HOLD: begin
                p.cs_n  = 1'b0;
                p.dq_oe = wr;
            end
            default: p = PINS_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_wait_counter.sv
module sram_wait_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R9: a loaded window counts down one per cycle
    assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
        (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int WR_LOAD = 1,
    parameter int RD_LOAD = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             cnt_expired,
    output logic             ready,
    output logic             accept,
    output phase_e           phase,
    output phase_e           next_phase,
    output logic             next_write,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             capture,
    output logic             finish
);

    localparam logic [CNT_W-1:0] WR_LOAD_V = CNT_W'(WR_LOAD);
    localparam logic [CNT_W-1:0] RD_LOAD_V = CNT_W'(RD_LOAD);

    phase_e phase_q;
    logic   op_write_q;

    assign ready  = (phase_q == PH_IDLE);
    assign accept = req_valid && ready;

    always_comb begin
        next_phase = phase_q;
        case (phase_q)
            PH_IDLE:   if (accept) next_phase = PH_SETUP;
            PH_SETUP:  next_phase = op_write_q ? PH_DATA : PH_STROBE;
            PH_DATA:   next_phase = PH_STROBE;
            PH_STROBE: if (cnt_expired) next_phase = op_write_q ? PH_HOLD : PH_IDLE;
            PH_HOLD:   next_phase = PH_IDLE;
            default:   next_phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            op_write_q <= 1'b0;
        end else begin
            phase_q <= next_phase;
            if (accept) op_write_q <= req_write;
        end
    end

    assign phase      = phase_q;
    assign next_write = accept ? req_write : op_write_q;
    assign cnt_load   = (next_phase == PH_STROBE) && (phase_q != PH_STROBE);
    assign cnt_val    = op_write_q ? WR_LOAD_V : RD_LOAD_V;
    assign capture    = (phase_q == PH_STROBE) && cnt_expired && !op_write_q;
    assign finish     = (phase_q != PH_IDLE) && (next_phase == PH_IDLE);

    // R2: once a request is taken the port reports busy
    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);

    // R2: the direction of a transfer cannot change while it runs
    assert_op_locked_R2: assert property (@(posedge clk) disable iff (rst)
        (!ready && !$past(accept)) |-> $stable(op_write_q));

endmodule

// File: rtl/sram_pin_driver.sv
module sram_pin_driver
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_e            next_phase,
    input  logic              next_write,
    input  logic              capture,
    input  logic              finish,
    input  logic [DATA_W-1:0] mem_dq_i,
    output pin_ctl_t          pins,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    pin_ctl_t          pins_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q  <= PINS_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            pins_q <= pins_for(next_phase, next_write);
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= mem_dq_i;
            done_q <= finish;
        end
    end

    assign pins     = pins_q;
    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;
    assign rdata    = rdata_q;
    assign done     = done_q;

    // R7: the two strobes never overlap
    assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(!pins_q.oe_n && !pins_q.we_n));

    // R7: any strobe implies the memory is selected
    assert_select_with_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (!pins_q.oe_n || !pins_q.we_n) |-> !pins_q.cs_n);

    // R3: data is already driven in the cycle before the write strobe falls
    assert_data_before_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(pins_q.we_n) |-> ($past(pins_q.dq_oe) && $stable(addr_q) && $stable(wdata_q)));

    // R4: one hold cycle after the write strobe rises
    assert_write_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_q.we_n) |-> (!pins_q.cs_n && pins_q.dq_oe && $stable(addr_q) && $stable(wdata_q)));

    // R11: never drive the data lines while the memory drives them
    assert_no_drive_on_read_R11: assert property (@(posedge clk) disable iff (rst)
        !pins_q.oe_n |-> !pins_q.dq_oe);

    // R8: completion is a single-cycle pulse with the pins idle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (pins_q == PINS_IDLE));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int CLK_NS = 20,
    parameter int READ_NS = 65,
    parameter int WRITE_NS = 80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    localparam int RD_CYC  = int'(read_len(READ_NS, CLK_NS));
    localparam int WR_CYC  = int'(write_len(WRITE_NS, READ_NS, CLK_NS));
    localparam int WR_LOAD = WR_CYC - 3;   // strobe spans cycles 3..WR_CYC
    localparam int RD_LOAD = RD_CYC - 2;   // strobe spans cycles 2..RD_CYC
    localparam int CNT_W   = $clog2(WR_CYC + 1);

    phase_e            phase;
    phase_e            next_phase;
    logic              accept;
    logic              next_write;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_expired;
    logic              capture;
    logic              finish;
    pin_ctl_t          pins;

    sram_phase_fsm #(
        .CNT_W   (CNT_W),
        .WR_LOAD (WR_LOAD),
        .RD_LOAD (RD_LOAD)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .cnt_expired (cnt_expired),
        .ready       (req_ready),
        .accept      (accept),
        .phase       (phase),
        .next_phase  (next_phase),
        .next_write  (next_write),
        .cnt_load    (cnt_load),
        .cnt_val     (cnt_val),
        .capture     (capture),
        .finish      (finish)
    );

    sram_wait_counter #(
        .CNT_W (CNT_W)
    ) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (cnt_expired)
    );

    sram_pin_driver #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .next_phase (next_phase),
        .next_write (next_write),
        .capture    (capture),
        .finish     (finish),
        .mem_dq_i   (mem_dq_i),
        .pins       (pins),
        .mem_addr   (mem_addr),
        .mem_dq_o   (mem_dq_o),
        .rdata      (rsp_rdata),
        .done       (rsp_done)
    );

    assign mem_cs_n  = pins.cs_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.dq_oe;

    // R2: address pins do not move while a transfer is under way
    assert_addr_locked_R2: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R6: fresh read data only appears with a load completion
    assert_rdata_changes_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(rsp_rdata) |-> rsp_done);

    // R8: completion follows the memory being deselected
    assert_done_after_select_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_done) |-> $rose(mem_cs_n));

    // R9: the phase register only leaves idle via an accepted request
    assert_idle_exit_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_IDLE && phase != PH_IDLE) |-> $past(accept));

endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

    localparam int CLK_PERIOD = 20;
    localparam int READ_NS    = 65;
    localparam int WRITE_NS   = 80;
    localparam int AW         = 8;
    localparam int DW         = 16;
    localparam int DEPTH      = 1 << AW;
    // R9: expected sequence lengths from the rounding rule
    localparam int RD_RAW = (READ_NS + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int R_LEN  = (RD_RAW < 2) ? 2 : RD_RAW;
    localparam int WR_RAW = (WRITE_NS + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int W_A    = (WR_RAW < 3) ? 3 : WR_RAW;
    localparam int W_LEN  = (W_A < R_LEN) ? R_LEN : W_A;
    // memory model: data valid once this many edges have passed with select low
    localparam int ACC_VALID = RD_RAW - 1;
    localparam logic [DW-1:0] JUNK = 16'hDEAD;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_o;
    logic          mem_dq_oe;
    logic [DW-1:0] mem_dq_i;
    logic          mem_cs_n;
    logic          mem_oe_n;
    logic          mem_we_n;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W   (AW),
        .DATA_W   (DW),
        .CLK_NS   (CLK_PERIOD),
        .READ_NS  (READ_NS),
        .WRITE_NS (WRITE_NS)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_i  (mem_dq_i),
        .mem_cs_n  (mem_cs_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n)
    );

    // behavioural asynchronous RAM with a cycle-counted access delay
    logic [DW-1:0] model_mem [DEPTH];
    int acc_cnt = 0;

    initial begin
        for (int i = 0; i < DEPTH; i++) model_mem[i] = JUNK;
    end

    always @(posedge clk) begin
        acc_cnt <= mem_cs_n ? 0 : acc_cnt + 1;
        if (!mem_cs_n && !mem_we_n && mem_dq_oe) model_mem[mem_addr] <= mem_dq_o;
    end

    assign mem_dq_i = (!mem_cs_n && !mem_oe_n && acc_cnt >= ACC_VALID) ? model_mem[mem_addr] : JUNK;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int pass);
        return DW'((a * 40503 + pass * 4099 + 17) ^ 16'h3C5A);
    endfunction

    function automatic logic [3:0] pinv();
        return {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe};
    endfunction

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog R2 actual=%0d expected<150000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // R7 / R11: strobe relations watched every cycle
    always @(negedge clk) begin
        if (!rst) begin
            chk(!(!mem_oe_n && !mem_we_n), "R7 strobes overlap", {30'd0, mem_oe_n, mem_we_n}, 32'h1);
            chk(!((!mem_oe_n || !mem_we_n) && mem_cs_n), "R7 strobe without select",
                {31'd0, mem_cs_n}, 32'h0);
            chk(!(!mem_oe_n && mem_dq_oe), "R11 drive during read", {31'd0, mem_dq_oe}, 32'h0);
        end
    end

    // Called at a negedge; returns at the negedge of the completion cycle.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
        chk(req_ready == 1'b1, "R10 ready at issue", {31'd0, req_ready}, 32'h1);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = a;
        req_wdata = d;
        for (int k = 1; k <= W_LEN + 2; k++) begin
            @(negedge clk);
            if (k <= W_LEN + 1) begin
                chk(mem_cs_n == 1'b0, "R3 select low in store", {31'd0, mem_cs_n}, 32'h0);
                chk(mem_addr == a, "R2 address held", 32'(mem_addr), 32'(a));
                chk(req_ready == 1'b0, "R2 busy", {31'd0, req_ready}, 32'h0);
                chk(rsp_done == 1'b0, "R8 no early done", {31'd0, rsp_done}, 32'h0);
                chk(mem_oe_n == 1'b1, "R3 read enable idle", {31'd0, mem_oe_n}, 32'h1);
            end
            if (k == 1) begin
                chk(mem_dq_oe == 1'b0 && mem_we_n == 1'b1, "R3 cycle1 address only",
                    {28'd0, pinv()}, 32'h6);
                req_valid = 1'b0;
            end
            if (k >= 2 && k <= W_LEN + 1) begin
                chk(mem_dq_oe == 1'b1 && mem_dq_o == d, "R3 data driven", 32'(mem_dq_o), 32'(d));
            end
            if (k == 2) begin
                chk(mem_we_n == 1'b1, "R3 strobe after data", {31'd0, mem_we_n}, 32'h1);
                if (poke) begin
                    req_valid = 1'b1;
                    req_write = 1'b0;
                    req_addr  = ~a;
                end
            end
            if (k >= 3 && k <= W_LEN) begin
                chk(mem_we_n == 1'b0, "R9 write strobe length", {31'd0, mem_we_n}, 32'h0);
            end
            if (k == W_LEN + 1) begin
                chk(mem_we_n == 1'b1, "R4 hold cycle strobe high", {31'd0, mem_we_n}, 32'h1);
                req_valid = 1'b0;
            end
            if (k == W_LEN + 2) begin
                chk(rsp_done == 1'b1, "R8 store done", {31'd0, rsp_done}, 32'h1);
                chk(pinv() == 4'hE, "R8 pins idle at done", {28'd0, pinv()}, 32'hE);
                chk(req_ready == 1'b1, "R10 ready at done", {31'd0, req_ready}, 32'h1);
            end
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        chk(req_ready == 1'b1, "R10 ready at issue", {31'd0, req_ready}, 32'h1);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = a;
        req_wdata = ~exp;
        for (int k = 1; k <= R_LEN + 1; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            if (k <= R_LEN) begin
                chk(mem_cs_n == 1'b0 && mem_addr == a, "R5 select and address",
                    32'(mem_addr), 32'(a));
                chk(mem_we_n == 1'b1, "R5 no write strobe", {31'd0, mem_we_n}, 32'h1);
                chk(mem_dq_oe == 1'b0, "R11 no drive in load", {31'd0, mem_dq_oe}, 32'h0);
                chk(rsp_done == 1'b0, "R8 no early done", {31'd0, rsp_done}, 32'h0);
                chk(mem_oe_n == (k == 1), "R9 read enable window", {31'd0, mem_oe_n},
                    {31'd0, (k == 1)});
            end else begin
                chk(rsp_done == 1'b1, "R8 load done", {31'd0, rsp_done}, 32'h1);
                chk(rsp_rdata == exp, "R6 read data", 32'(rsp_rdata), 32'(exp));
                chk(pinv() == 4'hE, "R8 pins idle at done", {28'd0, pinv()}, 32'hE);
            end
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(pinv() == 4'hE && rsp_done == 1'b0, "R11 idle pins", {28'd0, pinv()}, 32'hE);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: values while and right after reset
        chk(pinv() == 4'hE, "R1 reset pins", {28'd0, pinv()}, 32'hE);
        rst = 1'b0;
        @(negedge clk);
        chk(pinv() == 4'hE, "R1 pins after reset", {28'd0, pinv()}, 32'hE);
        chk(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 32'h1);
        chk(rsp_done == 1'b0, "R1 done low", {31'd0, rsp_done}, 32'h0);
        chk(W_LEN == 4 && R_LEN == 4, "R9 default lengths", 32'(W_LEN * 16 + R_LEN), 32'h44);

        // pass 0: fill every address back to back, poking requests while busy
        for (int a = 0; a < DEPTH; a++) do_write(AW'(a), pat(a, 0), (a % 7) == 3);
        idle_cycles(2);
        for (int a = 0; a < DEPTH; a++) do_read(AW'(a), pat(a, 0));
        idle_cycles(3);

        // pass 1: alternate store and load, reading a neighbour as well
        for (int a = 0; a < DEPTH; a++) begin
            do_write(AW'(a), pat(a, 1), 1'b0);
            do_read(AW'(a), pat(a, 1));
            do_read(AW'(a ^ 1), (((a ^ 1) < a) || (a % 2 == 1)) ? pat(a ^ 1, 1) : pat(a ^ 1, 0));
            if (a % 32 == 0) idle_cycles(1);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule